// File: doc/BRIEF.md
# Fractional one-second tick generator

The block derives a one-second tick from a slow oscillator clock of about 32 kHz. A static 32-bit configuration word sets the whole number of oscillator cycles in one second and a fraction of a cycle in steps of 1/256. Each second adds the fraction into an 8-bit accumulator. When that addition overflows, the second being started is one cycle longer. Over 256 seconds the total length is therefore 256·N + F cycles, and the average error stays well under one oscillator cycle.

One bit of the same word chooses the tick source. The source is either the internally counted second or an external second pulse. An external pulse is reduced to a tick on its rising edge. The output is a tick one cycle wide in the oscillator clock domain. Any other value of the word is taken only when a second begins, so a second that is under way always finishes with the length it started with.

Top module: `sec_pulse_gen`

## Requirements
- R1: The configuration word is decoded as follows. Bits 24:8 hold the integer cycle count N. Bits 7:0 hold the fraction F in units of 1/256 cycle. Bit 31 set to 1 selects the internal tick and set to 0 selects the external pulse. The remaining bits are ignored.
- R2: At the start of each second the block adds F to an 8-bit accumulator and keeps the low 8 bits. A carry out of that addition makes the second N+1 cycles long; without a carry it is N cycles.
- R3: Every tick is exactly one oscillator cycle wide.
- R4: The first rising edge with reset released starts the first second. That first second is N cycles long, plus one cycle if F alone carries.
- R5: Integer counts up to 2^17−1 are accepted, including values near 32768, and the resulting period is exact.
- R6: When N is 0 or 1, each second is 2 cycles long.
- R7: A change of N or F during a second leaves that second's length unchanged. The new values apply from the next second on.
- R8: While reset is asserted, the cycle counter and the accumulator are held at zero and the internal tick stays low.
- R9: In external mode the output is high only in the first cycle in which the external pulse input is high after having been low. Internal seconds do not reach the output, but the internal counter keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_word | input | 32 | Static configuration: N, F and the source select |
| ext_sec | input | 1 | External second pulse, synchronous to clk |
| sec_tick | output | 1 | One-cycle second tick |

## Verification
The bench sweeps N from 0 to 5 against fractions of 0, 1, 85, 128, 200 and 255, and compares every interval between ticks with an arithmetic model of the accumulator. A fraction of 0 separates a constant period from a fractional one. Fractions of 1 and 255 show whether the carry comes at the right second over a full 256-second cycle. N of 0 and 1 exercise the minimum-period clamp. A run at N = 32768 with F = 128 checks both the wide counter and a carry on alternate seconds. Further runs change the word in the middle of a second and drive long and short external pulses. These show whether a second ends with its starting length and whether external mode makes exactly one tick per pulse edge.

// File: rtl/sec_pulse_gen.sv
module sec_pulse_gen #(
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic        ext_sec,
  output logic        sec_tick
);
  localparam int LEN_W   = CNT_W + 1;
  localparam int SEL_BIT = 31;

  logic [CNT_W-1:0]  int_cnt;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic [LEN_W-1:0]  raw_len;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  cnt_q;
  logic              run_q;
  logic              ext_q;
  logic              wrap;
  logic              load;

  assign int_cnt = cfg_word[FRAC_W +: CNT_W];
  assign frac    = cfg_word[FRAC_W-1:0];
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac};
  assign raw_len = {1'b0, int_cnt} + LEN_W'(acc_sum[FRAC_W]);
  assign len     = (raw_len < LEN_W'(2)) ? LEN_W'(2) : raw_len;
  assign wrap    = run_q && (cnt_q == '0);
  assign load    = wrap || !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      run_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_sec;
      run_q <= 1'b1;
      if (load) begin
        cnt_q <= len - LEN_W'(1);
        acc_q <= acc_sum[FRAC_W-1:0];
      end else begin
        cnt_q <= cnt_q - LEN_W'(1);
      end
    end
  end

  assign sec_tick = cfg_word[SEL_BIT] ? wrap : (ext_sec & ~ext_q);
endmodule

module sec_pulse_chk #(
  parameter int CNT_W  = 17,
  parameter int FRAC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_word,
  input logic              ext_sec,
  input logic              sec_tick,
  input logic              run_q,
  input logic              wrap,
  input logic [FRAC_W-1:0] acc_q,
  input logic [CNT_W:0]    cnt_q
);
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (!sec_tick || !$stable(cfg_word[31])));

  a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(acc_q));

  a_r6_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q != '0));

  a_r9_ext_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_word[31] && $past(rst_n)) |-> (sec_tick == (ext_sec && !$past(ext_sec))));

  a_r8_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (acc_q == '0 && cnt_q == '0 && !wrap));
endmodule

bind sec_pulse_gen sec_pulse_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ext_sec(ext_sec),
  .sec_tick(sec_tick), .run_q(run_q), .wrap(wrap), .acc_q(acc_q), .cnt_q(cnt_q)
);

// File: tb/test_sec_pulse_gen.sv
module test_sec_pulse_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h8000_0000;
  logic ext_sec = 1'b0;
  logic sec_tick;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  int acc_m = 0;

  sec_pulse_gen i_sec_pulse_gen (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .ext_sec(ext_sec), .sec_tick(sec_tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk_cfg(input bit sel, input int n, input int f);
    return {sel, 6'd0, n[16:0], f[7:0]};
  endfunction

  function automatic int next_len(input int n, input int f);
    int s = acc_m + f;
    int p = n + (s >> 8);
    acc_m = s & 255;
    return (p < 2) ? 2 : p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    acc_m = 0;
    @(negedge clk);
    check("R8", int'(sec_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_tick(input int start, output int cnt);
    cnt = start;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      cnt++;
      if (sec_tick) break;
    end
  endtask

  task automatic run_case(input string req, input int n, input int f, input int secs);
    int got;
    cfg_word = mk_cfg(1'b1, n, f);
    do_reset();
    for (int k = 0; k < secs; k++) begin
      wait_tick(0, got);
      check(req, got, next_len(n, f));
    end
    @(negedge clk);
    check("R3", int'(sec_tick), 0);
  endtask

  initial begin
    int got;
    int fr [6] = '{0, 1, 85, 128, 200, 255};
    // R1 R2 R4: sweep of N and F
    for (int n = 2; n <= 5; n++)
      for (int j = 0; j < 6; j++)
        run_case("R2", n, fr[j], 24);
    // R6: integer counts below two
    for (int n = 0; n <= 1; n++)
      for (int j = 0; j < 6; j++)
        run_case("R6", n, fr[j], 12);
    // R2: full 256-second cycle with the smallest and largest fraction
    run_case("R2", 3, 1, 260);
    run_case("R2", 2, 255, 260);
    // R5: wide count, alternating carry
    run_case("R5", 32768, 128, 2);

    // R7: change mid-second
    cfg_word = mk_cfg(1'b1, 10, 0);
    do_reset();
    for (int i = 0; i < 3; i++) @(negedge clk);
    cfg_word = mk_cfg(1'b1, 4, 0);
    wait_tick(3, got);
    check("R7", got, 10);
    wait_tick(0, got);
    check("R7", got, 4);

    // R9: external mode
    cfg_word = mk_cfg(1'b0, 3, 0);
    do_reset();
    got = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      got += int'(sec_tick);
    end
    check("R9", got, 0);
    @(negedge clk);
    ext_sec = 1'b1;
    #1 check("R9", int'(sec_tick), 1);
    got = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 got += int'(sec_tick);
    end
    check("R9", got, 0);
    ext_sec = 1'b0;
    #1 check("R9", int'(sec_tick), 0);
    @(negedge clk);
    ext_sec = 1'b1;
    #1 check("R9", int'(sec_tick), 1);
    @(negedge clk);
    ext_sec = 1'b0;
    #1 check("R3", int'(sec_tick), 0);
    // R9: switch back, internal counter kept running, ticks keep period 3
    @(negedge clk);
    cfg_word = mk_cfg(1'b1, 3, 0);
    wait_tick(0, got);
    wait_tick(0, got);
    check("R9", got, 3);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule